// File: doc/BRIEF.md
# Framed Event Word Generator

This block produces a repeating stream of fixed-format test events as 32-bit words for a downstream FIFO, at most one word per clock. An event opens with a marker word of 0xAAAAAAAA, carries twenty-four payload words taken from a counter that steps by two, and closes with a marker word of 0xF0F0F0F0. Each payload word holds its count in the low bits, so the consumer reads it little-endian as 0x02, 0x04 and so on up to 0x30. The three kinds of word are never mixed inside one 32-bit word.

The consumer side is normally reached through an asynchronous FIFO. The block writes into it with a write-enable strobe, and the FIFO's full flag holds the block back word by word. Nothing is dropped or skipped while the FIFO stalls. A run-enable input lets events start. When run-enable falls in the middle of an event, the block completes that event through its closing marker before it goes idle. A 32-bit output counts completed events.

Top module: `evgen_top`

## Requirements
- R1: While the synchronous reset `rst` is high, `wrEn` is 0. After reset, `eventCount` reads 0 and the first accepted word is the opening marker.
- R2: Each event's first accepted word is 0xAAAAAAAA.
- R3: Exactly 24 payload words are accepted between the opening marker and the closing marker of an event.
- R4: The k-th payload word of every event (k = 1..24) equals 2*k as a 32-bit value (0x00000002 up to 0x00000030). It restarts at 0x00000002 in each event.
- R5: Each event's last accepted word is 0xF0F0F0F0.
- R6: While `fifoFull` is 1, `wrEn` is 0. The offered `wrData` stays unchanged until it is accepted, so no word is lost or skipped.
- R7: Between events, `wrEn` stays 0 while `runEn` is 0.
- R8: Inside an event, `wrEn` is 1 in every cycle in which `fifoFull` is 0, whatever `runEn` is. An event that has begun therefore always finishes.
- R9: `eventCount` rises by exactly one in the cycle after the closing marker is accepted, and holds at all other times.
- R10: With `runEn` 1 and `fifoFull` 0, a word is accepted every cycle. The opening marker of the next event directly follows the closing marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| runEn | input | 1 | Allows new events to start |
| fifoFull | input | 1 | Downstream FIFO is full. Holds back the write |
| wrData | output | 32 | Word offered to the FIFO |
| wrEn | output | 1 | Write strobe. The word is accepted on the clock edge where this is high |
| eventCount | output | 32 | Number of completed events since reset |

## Verification
A wrong sequencer position or payload counter shows up at the first accepted word after the fault. That word is a marker where a count is due, a count that is off by its step, or a closing marker after the wrong number of payload words. The bench compares every accepted word with a position model, so such faults show within one event (26 accepted words). A stall that lets the position advance without acceptance appears as a changed `wrData` in the cycle after `fifoFull` was high. A counting fault in `eventCount` is visible one cycle after a closing marker is accepted.

// File: rtl/evgen_pkg.sv
package evgen_pkg;

  // Which kind of word the sequencer is offering this cycle
  typedef enum logic [1:0] {
    PH_HEAD = 2'd0,
    PH_PAY  = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   hdrTake;   // opening marker accepted this cycle
    logic   payTake;   // payload word accepted this cycle
    logic   tailTake;  // closing marker accepted this cycle
    phase_e sel;       // word selector for the output mux
  } evStrobe_t;

endpackage

// File: rtl/evgen_ctrl.sv
module evgen_ctrl
  import evgen_pkg::*;
#(
  parameter int PAY_WORDS = 24,
  parameter int IDX_W     = (PAY_WORDS > 1) ? $clog2(PAY_WORDS) : 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      runEn,
  input  logic      fifoFull,
  output logic      wrEn,
  output evStrobe_t strb
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_WORDS - 1);

  phase_e           phase;
  logic [IDX_W-1:0] payIdx;
  logic             offerWord;
  logic             take;

  // Outside an event only runEn may start one; inside, always offer
  assign offerWord = (phase != PH_HEAD) || runEn;
  assign take      = !rst && !fifoFull && offerWord;
  assign wrEn      = take;

  always_comb begin
    strb.sel      = phase;
    strb.hdrTake  = take && (phase == PH_HEAD);
    strb.payTake  = take && (phase == PH_PAY);
    strb.tailTake = take && (phase == PH_TAIL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_HEAD;
      payIdx <= '0;
    end else if (take) begin
      unique case (phase)
        PH_HEAD: begin
          phase  <= PH_PAY;
          payIdx <= '0;
        end
        PH_PAY: begin
          if (payIdx == LAST_IDX) begin
            phase <= PH_TAIL;
          end else begin
            payIdx <= payIdx + 1'b1;
          end
        end
        PH_TAIL: phase <= PH_HEAD;
        default: phase <= PH_HEAD;
      endcase
    end
  end

endmodule

// File: rtl/evgen_dpath.sv
module evgen_dpath
  import evgen_pkg::*;
#(
  parameter int               WORD_W    = 32,
  parameter int               CNT_W     = 32,
  parameter int               STEP      = 2,
  parameter logic [WORD_W-1:0] HDR_WORD  = 32'hAAAA_AAAA,
  parameter logic [WORD_W-1:0] TAIL_WORD = 32'hF0F0_F0F0
) (
  input  logic              clk,
  input  logic              rst,
  input  evStrobe_t         strb,
  output logic [WORD_W-1:0] wrData,
  output logic [CNT_W-1:0]  eventCount
);

  localparam logic [WORD_W-1:0] STEP_W = WORD_W'(STEP);

  logic [WORD_W-1:0] payCnt;

  // Payload counter: reloaded by each opening marker, stepped per payload word
  always_ff @(posedge clk) begin
    if (rst) begin
      payCnt <= STEP_W;
    end else if (strb.hdrTake) begin
      payCnt <= STEP_W;
    end else if (strb.payTake) begin
      payCnt <= payCnt + STEP_W;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eventCount <= '0;
    end else if (strb.tailTake) begin
      eventCount <= eventCount + 1'b1;
    end
  end

  always_comb begin
    unique case (strb.sel)
      PH_HEAD: wrData = HDR_WORD;
      PH_PAY:  wrData = payCnt;
      PH_TAIL: wrData = TAIL_WORD;
      default: wrData = HDR_WORD;
    endcase
  end

endmodule

// File: rtl/evgen_top.sv
module evgen_top
  import evgen_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                CNT_W     = 32,
  parameter int                PAY_WORDS = 24,
  parameter int                STEP      = 2,
  parameter logic [WORD_W-1:0] HDR_WORD  = 32'hAAAA_AAAA,
  parameter logic [WORD_W-1:0] TAIL_WORD = 32'hF0F0_F0F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              runEn,
  input  logic              fifoFull,
  output logic [WORD_W-1:0] wrData,
  output logic              wrEn,
  output logic [CNT_W-1:0]  eventCount
);

  evStrobe_t strb;

  evgen_ctrl #(
    .PAY_WORDS(PAY_WORDS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .runEn    (runEn),
    .fifoFull (fifoFull),
    .wrEn     (wrEn),
    .strb     (strb)
  );

  evgen_dpath #(
    .WORD_W    (WORD_W),
    .CNT_W     (CNT_W),
    .STEP      (STEP),
    .HDR_WORD  (HDR_WORD),
    .TAIL_WORD (TAIL_WORD)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .wrData     (wrData),
    .eventCount (eventCount)
  );

endmodule

// File: rtl/evgen_chk.sv
module evgen_chk
  import evgen_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                CNT_W     = 32,
  parameter logic [WORD_W-1:0] HDR_WORD  = 32'hAAAA_AAAA,
  parameter logic [WORD_W-1:0] TAIL_WORD = 32'hF0F0_F0F0
) (
  input logic              clk,
  input logic              rst,
  input logic              runEn,
  input logic              fifoFull,
  input logic [WORD_W-1:0] wrData,
  input logic              wrEn,
  input logic [CNT_W-1:0]  eventCount,
  input phase_e            phaseNow
);

  logic tailAcc;
  assign tailAcc = wrEn && (wrData == TAIL_WORD);

  // R1: no write during reset
  always_comb begin
    if (rst) begin
      p_reset_quiet_r1: assert (!wrEn);
    end
  end

  // R6: backpressure blocks the write
  p_full_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    fifoFull |-> !wrEn);

  // R6: offered word held across a stall
  p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
    fifoFull |=> $stable(wrData));

  // R7: idle between events without runEn
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (phaseNow == PH_HEAD && !runEn) |-> !wrEn);

  // R8: an open event keeps writing whenever space exists
  p_finish_event_r8: assert property (@(posedge clk) disable iff (rst)
    (phaseNow != PH_HEAD && !fifoFull) |-> wrEn);

  // R9: count steps after a closing marker
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    tailAcc |=> (eventCount == $past(eventCount) + 1'b1));

  // R9: count holds otherwise
  p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !tailAcc |=> $stable(eventCount));

  // R10: opening marker follows the closing marker
  p_next_head_r10: assert property (@(posedge clk) disable iff (rst)
    tailAcc |=> (wrData == HDR_WORD));

endmodule

bind evgen_top evgen_chk #(
  .WORD_W    (WORD_W),
  .CNT_W     (CNT_W),
  .HDR_WORD  (HDR_WORD),
  .TAIL_WORD (TAIL_WORD)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .runEn      (runEn),
  .fifoFull   (fifoFull),
  .wrData     (wrData),
  .wrEn       (wrEn),
  .eventCount (eventCount),
  .phaseNow   (strb.sel)
);

// File: tb/evgen_top_tb.sv
`timescale 1ns/1ps
module evgen_top_tb;

  localparam int PAY = 24;
  localparam int LAST_POS = PAY + 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        runEn;
  logic        fifoFull;
  logic [31:0] wrData;
  logic        wrEn;
  logic [31:0] eventCount;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model state
  int          pos = 0;
  int          payCount = 0;
  logic [31:0] expCount = 0;
  bit          prevFull = 1'b0;
  bit          prevRst  = 1'b1;
  logic [31:0] prevData = 0;

  always #10 clk = ~clk;

  evgen_top u_dut (
    .clk        (clk),
    .rst        (rst),
    .runEn      (runEn),
    .fifoFull   (fifoFull),
    .wrData     (wrData),
    .wrEn       (wrEn),
    .eventCount (eventCount)
  );

  function automatic logic [31:0] expWord(int p);
    if (p == 0) return 32'hAAAA_AAAA;
    if (p == LAST_POS) return 32'hF0F0_F0F0;
    return 32'(2 * p);
  endfunction

  function automatic string tagOf(int p);
    if (p == 0) return "R2";
    if (p == LAST_POS) return "R5";
    return "R4";
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, sample 5 ns before the next posedge
  task automatic step(bit r, bit run, bit full);
    bit expEn;
    @(negedge clk);
    rst = r; runEn = run; fifoFull = full;
    #5;
    expEn = !r && !full && (pos != 0 || run);
    if (r) check(wrEn == 1'b0, "R1 wrEn in reset", 32'(wrEn), 0);
    else if (full) check(wrEn == 1'b0, "R6 wrEn while full", 32'(wrEn), 0);
    else if (pos != 0) check(wrEn == expEn, "R8 wrEn inside event", 32'(wrEn), 32'(expEn));
    else if (!run) check(wrEn == expEn, "R7 wrEn idle", 32'(wrEn), 32'(expEn));
    else check(wrEn == expEn, "R10 wrEn start", 32'(wrEn), 32'(expEn));
    if (!r && !prevRst && prevFull)
      check(wrData == prevData, "R6 word held", wrData, prevData);
    if (!prevRst) check(eventCount == expCount, "R9 eventCount", eventCount, expCount);
    if (!r && wrEn) begin
      check(wrData == expWord(pos), tagOf(pos), wrData, expWord(pos));
      if (pos == 0) payCount = 0;
      else if (pos == LAST_POS) begin
        check(payCount == PAY, "R3 payload words", 32'(payCount), 32'(PAY));
        expCount = expCount + 1;
      end else payCount++;
      pos = (pos == LAST_POS) ? 0 : pos + 1;
    end
    if (r) begin
      pos = 0; expCount = 0; payCount = 0;
    end
    prevFull = full; prevRst = r; prevData = wrData;
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd2024);
    rst = 1'b1; runEn = 1'b1; fifoFull = 1'b0;
    // R1: reset quiet, then clean start
    for (int i = 0; i < 3; i++) step(1, 1, 0);
    step(0, 0, 0);
    check(eventCount == 0, "R1 count after reset", eventCount, 0);
    check(wrData == 32'hAAAA_AAAA, "R1 first word offered", wrData, 32'hAAAA_AAAA);
    // R10: back-to-back events without stalls
    for (int i = 0; i < 60; i++) step(0, 1, 0);
    // Random backpressure and run-enable
    for (int i = 0; i < 1500; i++)
      step(0, ($urandom % 10) != 0, ($urandom % 4) == 0);
    // R6: long stall inside an event
    while (pos != 5) step(0, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 1, 1);
    // R8: drop runEn mid-event, event must still complete
    while (pos != 7) step(0, 1, 0);
    for (int i = 0; i < 100; i++) step(0, 0, ($urandom % 3) == 0);
    check(pos == 0, "R8 event completed", 32'(pos), 0);
    // R7: idle stays idle
    for (int i = 0; i < 20; i++) step(0, 0, 0);
    check(wrData == 32'hAAAA_AAAA, "R7 idle offers opening marker", wrData, 32'hAAAA_AAAA);
    // R1: reset in the middle of an event
    while (pos != 10) step(0, 1, 0);
    step(1, 1, 0);
    step(1, 1, 0);
    step(0, 1, 0);
    check(eventCount == 0, "R1 count cleared", eventCount, 0);
    for (int i = 0; i < 60; i++) step(0, 1, ($urandom % 5) == 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule